// File: doc/BRIEF.md
# Configuration Strap Sampler

This block captures the board-level configuration straps of a serial-link receiver and holds the decoded settings for the rest of the chip. The straps are sampled once after reset. They are sampled again each time the active-low power-down input is released. At every other time the held settings stay frozen, whatever the strap pins do.

Each of the two device-address straps is a three-level pin. The analog front end reports it as a pair of "pulled low" and "pulled high" indications, and neither indication set means the pin is open. The block turns the two pins into an address index in the range 0 to 8. It also turns the equalizer-select strap into a 4-bit equalizer tuning code and latches the rate-range and spread-spectrum straps as they are.

Capture does not happen at once. It waits a configurable settle time after power is released, and a valid flag then tells downstream logic that the settings can be used.

Top module: `strap_sampler`

## Requirements
- R1: While reset is asserted, `cfgValid` is 0 and `devAddrIdx`, `eqTune`, `lowRateRange` and `spreadEn` are all 0.
- R2: Capture happens on the rising clock edge that is `SETTLE_CYCLES` edges after the first edge at which `pwrDnN` is seen high, counted after reset release or after a power-down. The outputs take the strap values present at that edge, and `cfgValid` rises on the same edge.
- R3: Every release of power-down starts a fresh settle window and a fresh capture, so strap values changed during power-down appear on the outputs.
- R4: While no capture is in progress, changes on any strap input have no effect on `devAddrIdx`, `eqTune`, `lowRateRange` or `spreadEn`.
- R5: `cfgValid` goes to 0 on the clock edge after `pwrDnN` is sampled low. The held fields keep their values during power-down.
- R6: Each address pin `addrPinN[1:0]` uses bit 0 for "pulled low" and bit 1 for "pulled high". The level code is low=0 when bit 0 is set (even if bit 1 is also set), high=2 when only bit 1 is set, and open=1 when neither bit is set. The index is `devAddrIdx = 3*level(addrPin1) + level(addrPin0)`.
- R7: The equalizer-select strap maps to `eqTune` = 4'b1001 when low (strong boost) and 4'b0100 when high (mild boost).
- R8: `lowRateRange` captures the rate-select strap directly (1 = low pixel-clock range). `spreadEn` captures the spread-enable strap directly (1 = spread spectrum requested).
- R9: If `pwrDnN` falls during the settle window, no capture takes place. The next release restarts the full settle window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Active-low power-down, synchronous to clk |
| addrPin0 | input | 2 | Address strap 0 level indications {high, low} |
| addrPin1 | input | 2 | Address strap 1 level indications {high, low} |
| eqSelPin | input | 1 | Equalizer-select strap |
| rateSelPin | input | 1 | Rate-range strap |
| spreadPin | input | 1 | Spread-enable strap |
| cfgValid | output | 1 | Held settings are valid |
| devAddrIdx | output | 4 | Device address index 0..8 |
| eqTune | output | 4 | Equalizer tuning code |
| lowRateRange | output | 1 | Low pixel-clock range selected |
| spreadEn | output | 1 | Spread spectrum requested |

## Verification
Several properties are checked on every cycle:
- The settle counter never passes its limit.
- The address index stays below nine.
- The tuning code is always one of the two legal codes or the reset value.
- The held fields stay stable in any cycle without a capture strobe.
- The flag drops after a sampled power-down.

The per-cycle reference model, together with the bench scenarios, shows the things only a sequence can show:
- the exact edge on which capture lands;
- that a release after power-down picks up new strap values;
- that a power-down inside the settle window cancels the capture;
- that the address decode is correct across all nine level pairs and the both-indications case.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int ADDR_PINS   = 2;
  localparam int ADDR_COMBOS = 3 ** ADDR_PINS;
  localparam int ADDR_IDX_W  = $clog2(ADDR_COMBOS);
  localparam int EQ_W        = 4;

  localparam logic [EQ_W-1:0] EQ_TUNE_STRONG = 4'b1001;
  localparam logic [EQ_W-1:0] EQ_TUNE_MILD   = 4'b0100;

  localparam logic [1:0] LVL_LOW  = 2'd0;
  localparam logic [1:0] LVL_OPEN = 2'd1;
  localparam logic [1:0] LVL_HIGH = 2'd2;

  typedef enum logic [1:0] {
    ST_DOWN   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_READY  = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic capture;
  } strapStrobe_t;

  typedef struct packed {
    logic [ADDR_IDX_W-1:0] addrIdx;
    logic [EQ_W-1:0]       eqTune;
    logic                  lowRate;
    logic                  spreadEn;
  } strapCfg_t;

endpackage

// File: rtl/strap_tern_dec.sv
module strap_tern_dec
  import strap_cfg_pkg::*;
(
  input  logic [1:0] pinLvl,
  output logic [1:0] lvlCode
);

  always_comb begin
    if (pinLvl[0])      lvlCode = LVL_LOW;
    else if (pinLvl[1]) lvlCode = LVL_HIGH;
    else                lvlCode = LVL_OPEN;
  end

endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_cfg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pwrDnN,
  output strapStrobe_t strobe,
  output logic         cfgValid
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  ctrlState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stateD         = stateQ;
    cntD           = cntQ;
    strobe.capture = 1'b0;
    unique case (stateQ)
      ST_DOWN: begin
        if (pwrDnN) begin
          stateD = ST_SETTLE;
          cntD   = '0;
        end
      end
      ST_SETTLE: begin
        if (!pwrDnN) begin
          stateD = ST_DOWN;
        end else if (cntQ == CNT_LAST) begin
          stateD         = ST_READY;
          strobe.capture = 1'b1;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_READY: begin
        if (!pwrDnN) stateD = ST_DOWN;
      end
      default: stateD = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_DOWN;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign cfgValid = (stateQ == ST_READY);

  // R5
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> !cfgValid);

  // R2
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_LAST);

  // R9
  rise_needs_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgValid) |-> $past(pwrDnN));

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strapStrobe_t              strobe,
  input  logic [ADDR_PINS-1:0][1:0] addrPins,
  input  logic                      eqSelPin,
  input  logic                      rateSelPin,
  input  logic                      spreadPin,
  output strapCfg_t                 cfgQ
);

  logic [ADDR_PINS-1:0][1:0] lvlCodes;
  logic [ADDR_IDX_W-1:0]     addrIdxD;
  strapCfg_t                 cfgD;

  for (genvar gi = 0; gi < ADDR_PINS; gi++) begin : g_addrDec
    strap_tern_dec u_dec (
      .pinLvl  (addrPins[gi]),
      .lvlCode (lvlCodes[gi])
    );
  end

  always_comb begin
    int acc;
    int weight;
    acc    = 0;
    weight = 1;
    for (int i = 0; i < ADDR_PINS; i++) begin
      acc    = acc + int'(lvlCodes[i]) * weight;
      weight = weight * 3;
    end
    addrIdxD = ADDR_IDX_W'(acc);
  end

  always_comb begin
    cfgD.addrIdx  = addrIdxD;
    cfgD.eqTune   = eqSelPin ? EQ_TUNE_MILD : EQ_TUNE_STRONG;
    cfgD.lowRate  = rateSelPin;
    cfgD.spreadEn = spreadPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cfgQ <= '0;
    else if (strobe.capture) cfgQ <= cfgD;
  end

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(cfgQ));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.addrIdx < ADDR_IDX_W'(ADDR_COMBOS));

  // R7
  eq_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.eqTune == EQ_TUNE_STRONG) || (cfgQ.eqTune == EQ_TUNE_MILD) ||
    (cfgQ.eqTune == '0));

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_cfg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDnN,
  input  logic [1:0] addrPin0,
  input  logic [1:0] addrPin1,
  input  logic       eqSelPin,
  input  logic       rateSelPin,
  input  logic       spreadPin,
  output logic       cfgValid,
  output logic [3:0] devAddrIdx,
  output logic [3:0] eqTune,
  output logic       lowRateRange,
  output logic       spreadEn
);

  strapStrobe_t strobe;
  strapCfg_t    cfgQ;

  strap_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwrDnN   (pwrDnN),
    .strobe   (strobe),
    .cfgValid (cfgValid)
  );

  strap_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addrPins   ({addrPin1, addrPin0}),
    .eqSelPin   (eqSelPin),
    .rateSelPin (rateSelPin),
    .spreadPin  (spreadPin),
    .cfgQ       (cfgQ)
  );

  assign devAddrIdx   = cfgQ.addrIdx;
  assign eqTune       = cfgQ.eqTune;
  assign lowRateRange = cfgQ.lowRate;
  assign spreadEn     = cfgQ.spreadEn;

  // R2
  valid_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgValid) |-> $past(strobe.capture));

endmodule

// File: tb/strap_sampler_tb.sv
module strap_sampler_tb;

  localparam int N = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrDnN = 1'b1;
  logic [1:0] addrPin0 = 2'b10;
  logic [1:0] addrPin1 = 2'b01;
  logic eqSelPin = 1'b0;
  logic rateSelPin = 1'b1;
  logic spreadPin = 1'b1;
  logic cfgValid;
  logic [3:0] devAddrIdx;
  logic [3:0] eqTune;
  logic lowRateRange;
  logic spreadEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strap_sampler #(.SETTLE_CYCLES(N)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN),
    .addrPin0(addrPin0), .addrPin1(addrPin1),
    .eqSelPin(eqSelPin), .rateSelPin(rateSelPin), .spreadPin(spreadPin),
    .cfgValid(cfgValid), .devAddrIdx(devAddrIdx), .eqTune(eqTune),
    .lowRateRange(lowRateRange), .spreadEn(spreadEn)
  );

  function automatic int lvl(logic [1:0] p);
    if (p[0]) return 0;
    if (p[1]) return 2;
    return 1;
  endfunction

  // reference model
  int  highRun = 0;
  bit  mValid = 0;
  int  mAddr = 0;
  int  mEq = 0;
  bit  mRate = 0;
  bit  mSpread = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      highRun = 0; mValid = 0; mAddr = 0; mEq = 0; mRate = 0; mSpread = 0;
    end else if (!pwrDnN) begin
      highRun = 0; mValid = 0;
    end else if (highRun <= N) begin
      highRun++;
      if (highRun == N + 1) begin
        mValid  = 1;
        mAddr   = 3 * lvl(addrPin1) + lvl(addrPin0);
        mEq     = eqSelPin ? 4 : 9;
        mRate   = rateSelPin;
        mSpread = spreadPin;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 model valid", int'(cfgValid), int'(mValid));
      chk("R6 model addr", int'(devAddrIdx), mAddr);
      chk("R7 model eq", int'(eqTune), mEq);
      chk("R8 model rate", int'(lowRateRange), int'(mRate));
      chk("R8 model spread", int'(spreadEn), int'(mSpread));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseDown();
    pwrDnN = 1'b0;
    tick(1);
    pwrDnN = 1'b1;
  endtask

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 valid", int'(cfgValid), 0);
    chk("R1 addr", int'(devAddrIdx), 0);
    chk("R1 eq", int'(eqTune), 0);
    chk("R1 rate/spread", int'({lowRateRange, spreadEn}), 0);
    rstN = 1'b1;
    tick(N);
    chk("R2 not yet valid", int'(cfgValid), 0);
    tick(1);
    chk("R2 valid on time", int'(cfgValid), 1);
    chk("R6 addr hi/lo", int'(devAddrIdx), 2);
    chk("R7 eq low strap", int'(eqTune), 9);
    chk("R8 rate", int'(lowRateRange), 1);
    chk("R8 spread", int'(spreadEn), 1);

    // R4 strap changes ignored while held
    addrPin0 = 2'b00; addrPin1 = 2'b10; eqSelPin = 1'b1;
    rateSelPin = 1'b0; spreadPin = 1'b0;
    tick(5);
    chk("R4 addr held", int'(devAddrIdx), 2);
    chk("R4 eq held", int'(eqTune), 9);
    chk("R4 rate/spread held", int'({lowRateRange, spreadEn}), 3);

    // R5 power-down clears valid, keeps fields
    pwrDnN = 1'b0;
    tick(1);
    chk("R5 valid cleared", int'(cfgValid), 0);
    tick(3);
    chk("R5 addr kept", int'(devAddrIdx), 2);
    chk("R5 eq kept", int'(eqTune), 9);

    // R3 re-sample on release
    pwrDnN = 1'b1;
    tick(N + 1);
    chk("R3 valid", int'(cfgValid), 1);
    chk("R3 addr open/high", int'(devAddrIdx), 7);
    chk("R3 eq mild", int'(eqTune), 4);
    chk("R3 rate/spread", int'({lowRateRange, spreadEn}), 0);

    // R9 abort inside settle window
    addrPin0 = 2'b01; addrPin1 = 2'b01;
    pulseDown();
    tick(3);
    pwrDnN = 1'b0;
    tick(2);
    pwrDnN = 1'b1;
    tick(N);
    chk("R9 no early capture", int'(cfgValid), 0);
    chk("R9 addr untouched", int'(devAddrIdx), 7);
    tick(1);
    chk("R9 capture after restart", int'(cfgValid), 1);
    chk("R9 addr low/low", int'(devAddrIdx), 0);

    // R6 all nine combinations plus both-indications case
    for (int a1 = 0; a1 < 3; a1++) begin
      for (int a0 = 0; a0 < 3; a0++) begin
        addrPin0 = (a0 == 0) ? 2'b01 : (a0 == 1) ? 2'b00 : 2'b10;
        addrPin1 = (a1 == 0) ? 2'b01 : (a1 == 1) ? 2'b00 : 2'b10;
        pulseDown();
        tick(N + 1);
        chk("R6 addr combo", int'(devAddrIdx), 3 * a1 + a0);
      end
    end
    addrPin0 = 2'b11; addrPin1 = 2'b10; eqSelPin = 1'b0;
    pulseDown();
    tick(N + 1);
    chk("R6 both bits means low", int'(devAddrIdx), 6);
    chk("R7 eq strong", int'(eqTune), 9);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule